// File: doc/BRIEF.md
# NAND Flash Opcode Sequencer

This block is a small programmable sequencer for an 8-bit NAND flash channel. Software loads a 32-bit program word of eight 4-bit opcodes, a word of four command bytes, a word of four user byte slots, a byte count, a column address, a row address, a ready-wait timeout and an address geometry. A single start pulse then runs the opcodes, most significant nibble first. Each opcode becomes command, address or data strobes on the flash bus, or a wait for the ready line followed by one of those actions.

Bulk transfers move the programmed number of bytes between the flash and a page buffer. The buffer sits outside the block and is reached through a simple address, write-enable and data port with a read path of zero latency. Single-byte operations use the user slot word instead. A slot pointer there starts at the top byte and steps once per slot opcode. The flash timing is reduced to one strobe per cycle. Completion is marked by a one-cycle done pulse, and busy is low at that point.

Top module: `nand_seq`

## Requirements
- R1: After reset the program, command, slot, byte-count, address, timeout and geometry registers are all zero, busy, done and timeout are low and no strobe is driven. A start with the reset program completes with no strobe.
- R2: Opcodes run from bits 31:28 down to bits 3:0. Opcode 0x0 ends the run, and later nibbles are not executed. A run also ends after the eighth opcode.
- R3: Opcodes 0x4 to 0x7 each drive one command cycle (cle and we high) carrying command byte 0 to 3. Byte 0 is bits 31:24 of the command word and byte 3 is bits 7:0.
- R4: Opcode 0x1 drives the column address as address cycles (ale and we high), low byte first. It uses two cycles when geometry bit 0 is set and one cycle otherwise.
- R5: Opcode 0x2 drives the row address low byte first, in (geometry bits 2:1) + 1 address cycles.
- R6: The slot pointer resets to slot 0 (bits 31:24) at each start. It steps by one after every 0x3 (address byte from a slot), 0x9 (write a slot byte) and 0xB/0xF (read a byte into a slot), and it wraps from slot 3 to slot 0.
- R7: Opcode 0x8 writes byte-count bytes from buffer addresses 0 upward. Opcodes 0xA and 0xE read byte-count flash bytes into buffer addresses 0 upward. A count of zero produces no data cycle.
- R8: Opcodes 0xC to 0xF produce no strobe while the ready input is low. Once ready is high they act as command byte 0, command byte 1, a bulk read and a single-byte read, respectively.
- R9: If ready stays low for more than the timeout value in cycles, the sticky timeout output is set and the paired action still runs. The flag clears only at the next accepted start.
- R10: Busy is high from the cycle after an accepted start until completion. Done is a one-cycle pulse with busy low. Configuration writes and start pulses are ignored while busy.

Configuration select codes: 0 program, 1 command bytes, 2 slots, 3 byte count, 4 column (bits 15:0), 5 row, 6 timeout, 7 geometry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| data_o | output | 32 | User slot word |
| busy_o | output | 1 | Program running |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Sticky ready-wait timeout |
| fl_cle_o | output | 1 | Command cycle |
| fl_ale_o | output | 1 | Address cycle |
| fl_we_o | output | 1 | Write strobe |
| fl_re_o | output | 1 | Read strobe |
| fl_dq_o | output | 8 | Flash bus out |
| fl_dq_i | input | 8 | Flash bus in, sampled during a read strobe |
| fl_rdy_i | input | 1 | Ready (high) / busy (low) |
| buf_addr_o | output | BUF_AW | Buffer address |
| buf_we_o | output | 1 | Buffer write |
| buf_wdata_o | output | 8 | Buffer write data |
| buf_rdata_i | input | 8 | Buffer read data, same cycle |

## Verification
An accepted start raises busy one cycle later. Each opcode then spends one decode cycle with no strobe, followed by its strobe cycles back to back. Done rises in the cycle after the last strobe, or one cycle after the decode of a zero opcode. Since the exact strobe cycles shift with decode and wait cycles, the bench does not tie checks to fixed cycles. It queues the expected strobe kinds and bytes in order, and a monitor compares every strobe at the falling edge. Slot, buffer and timeout results are sampled only after done, when they are settled.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEC, ST_WAIT, ST_CMD, ST_ADDR, ST_WR, ST_RD
  } st_e;

  localparam logic [2:0] SEL_PROG = 3'd0;
  localparam logic [2:0] SEL_CMD  = 3'd1;
  localparam logic [2:0] SEL_SLOT = 3'd2;
  localparam logic [2:0] SEL_BCNT = 3'd3;
  localparam logic [2:0] SEL_COL  = 3'd4;
  localparam logic [2:0] SEL_ROW  = 3'd5;
  localparam logic [2:0] SEL_TMO  = 3'd6;
  localparam logic [2:0] SEL_GEOM = 3'd7;

  localparam logic [3:0] OP_END  = 4'h0;
  localparam logic [3:0] OP_COL  = 4'h1;
  localparam logic [3:0] OP_ROW  = 4'h2;
  localparam logic [3:0] OP_UADR = 4'h3;
  localparam logic [3:0] OP_WBUF = 4'h8;
  localparam logic [3:0] OP_WONE = 4'h9;
  localparam logic [3:0] OP_RBUF = 4'hA;
  localparam logic [3:0] OP_RONE = 4'hB;
  localparam logic [3:0] OP_WC0  = 4'hC;
  localparam logic [3:0] OP_WC1  = 4'hD;
  localparam logic [3:0] OP_WRB  = 4'hE;
  localparam logic [3:0] OP_WRS  = 4'hF;

  function automatic logic [3:0] op_at(logic [31:0] w, logic [2:0] i);
    logic [31:0] s;
    s = w >> {3'd7 - i, 2'b00};
    return s[3:0];
  endfunction

  // byte 0 = bits 31:24
  function automatic logic [7:0] byte_msb(logic [31:0] w, logic [1:0] i);
    logic [31:0] s;
    s = w >> {2'd3 - i, 3'b000};
    return s[7:0];
  endfunction

  // byte 0 = bits 7:0
  function automatic logic [7:0] byte_lsb(logic [31:0] w, logic [1:0] i);
    logic [31:0] s;
    s = w >> {i, 3'b000};
    return s[7:0];
  endfunction
endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
  import nand_seq_pkg::*;
#(
  parameter int BUF_AW = 8,
  parameter int TMO_W  = 16,
  localparam int CW    = BUF_AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_sel_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              slot_we_i,
  input  logic [1:0]        slot_idx_i,
  input  logic [7:0]        slot_wdata_i,
  output logic [31:0]       prog_o,
  output logic [31:0]       cmd_o,
  output logic [31:0]       slot_o,
  output logic [CW-1:0]     bcnt_o,
  output logic [15:0]       col_o,
  output logic [31:0]       row_o,
  output logic [TMO_W-1:0]  tmo_o,
  output logic              col2_o,
  output logic [1:0]        rowcyc_o
);
  logic [2:0] geom_q;
  logic       wr_ok;

  assign wr_ok    = cfg_we_i && !busy_i;
  assign col2_o   = geom_q[0];
  assign rowcyc_o = geom_q[2:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_o <= '0;
      cmd_o  <= '0;
      slot_o <= '0;
      bcnt_o <= '0;
      col_o  <= '0;
      row_o  <= '0;
      tmo_o  <= '0;
      geom_q <= '0;
    end else if (slot_we_i) begin
      case (slot_idx_i)
        2'd0: slot_o[31:24] <= slot_wdata_i;
        2'd1: slot_o[23:16] <= slot_wdata_i;
        2'd2: slot_o[15:8]  <= slot_wdata_i;
        default: slot_o[7:0] <= slot_wdata_i;
      endcase
    end else if (wr_ok) begin
      case (cfg_sel_i)
        SEL_PROG: prog_o <= cfg_wdata_i;
        SEL_CMD:  cmd_o  <= cfg_wdata_i;
        SEL_SLOT: slot_o <= cfg_wdata_i;
        SEL_BCNT: bcnt_o <= cfg_wdata_i[CW-1:0];
        SEL_COL:  col_o  <= cfg_wdata_i[15:0];
        SEL_ROW:  row_o  <= cfg_wdata_i;
        SEL_TMO:  tmo_o  <= cfg_wdata_i[TMO_W-1:0];
        default:  geom_q <= cfg_wdata_i[2:0];
      endcase
    end
  end
endmodule

// File: rtl/nand_seq_wait.sv
module nand_seq_wait #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             rdy_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             exit_o,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;
  logic             at_lim;

  assign at_lim    = (cnt_q == limit_i);
  assign exit_o    = run_i && (rdy_i || at_lim);
  assign expired_o = run_i && !rdy_i && at_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + TMO_W'(1);
  end
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_seq_pkg::*;
#(
  parameter int BUF_AW = 8,
  localparam int CW    = BUF_AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [31:0]       prog_i,
  input  logic [31:0]       cmd_i,
  input  logic [31:0]       slot_i,
  input  logic [CW-1:0]     bcnt_i,
  input  logic [15:0]       col_i,
  input  logic [31:0]       row_i,
  input  logic              col2_i,
  input  logic [1:0]        rowcyc_i,
  input  logic              wait_exit_i,
  input  logic              wait_exp_i,
  output logic              wait_run_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              slot_we_o,
  output logic [1:0]        slot_idx_o,
  output logic [7:0]        slot_wdata_o,
  output logic              fl_cle_o,
  output logic              fl_ale_o,
  output logic              fl_we_o,
  output logic              fl_re_o,
  output logic [7:0]        fl_dq_o,
  input  logic [7:0]        fl_dq_i,
  output logic [BUF_AW-1:0] buf_addr_o,
  output logic              buf_we_o,
  output logic [7:0]        buf_wdata_o,
  input  logic [7:0]        buf_rdata_i
);
  st_e            st_q;
  logic [2:0]     idx_q;
  logic [1:0]     slot_q;
  logic [3:0]     op_q, cur_op;
  logic [CW-1:0]  cnt_q, ncyc;
  logic           done_q, to_q;
  logic           bulk, single, last, zero_cnt, adv, fin;
  logic [1:0]     cidx;
  logic [7:0]     slot_byte;

  assign cur_op    = op_at(prog_i, idx_q);
  assign bulk      = (op_q == OP_WBUF) || (op_q == OP_RBUF) || (op_q == OP_WRB);
  assign single    = (op_q == OP_UADR) || (op_q == OP_WONE) ||
                     (op_q == OP_RONE) || (op_q == OP_WRS);
  assign zero_cnt  = (bcnt_i == '0);
  assign cidx      = op_q[3] ? {1'b0, op_q[0]} : op_q[1:0];
  assign slot_byte = byte_msb(slot_i, slot_q);

  always_comb begin
    case (op_q)
      OP_COL:                   ncyc = col2_i ? CW'(2) : CW'(1);
      OP_ROW:                   ncyc = CW'(rowcyc_i) + CW'(1);
      OP_WBUF, OP_RBUF, OP_WRB: ncyc = bcnt_i;
      default:                  ncyc = CW'(1);
    endcase
  end
  assign last = (cnt_q == ncyc - CW'(1));

  always_comb begin
    fin = (st_q == ST_DEC) && (cur_op == OP_END);
    adv = 1'b0;
    case (st_q)
      ST_DEC:  adv = ((cur_op == OP_WBUF) || (cur_op == OP_RBUF)) && zero_cnt;
      ST_WAIT: adv = wait_exit_i && (op_q == OP_WRB) && zero_cnt;
      ST_CMD:  adv = 1'b1;
      ST_ADDR, ST_WR, ST_RD: adv = last;
      default: adv = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      slot_q <= '0;
      op_q   <= OP_END;
      cnt_q  <= '0;
      done_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if ((st_q == ST_WAIT) && wait_exp_i) to_q <= 1'b1;
      if (((st_q == ST_ADDR) || (st_q == ST_WR) || (st_q == ST_RD)) && single)
        slot_q <= slot_q + 2'd1;
      if (fin || (adv && (idx_q == 3'd7))) begin
        st_q   <= ST_IDLE;
        done_q <= 1'b1;
      end else if (adv) begin
        idx_q <= idx_q + 3'd1;
        st_q  <= ST_DEC;
      end else begin
        case (st_q)
          ST_IDLE: if (start_i) begin
            st_q   <= ST_DEC;
            idx_q  <= '0;
            slot_q <= '0;
            to_q   <= 1'b0;
          end
          ST_DEC: begin
            op_q  <= cur_op;
            cnt_q <= '0;
            case (cur_op)
              OP_COL, OP_ROW, OP_UADR: st_q <= ST_ADDR;
              OP_WBUF, OP_WONE:        st_q <= ST_WR;
              OP_RBUF, OP_RONE:        st_q <= ST_RD;
              OP_WC0, OP_WC1, OP_WRB, OP_WRS: st_q <= ST_WAIT;
              default:                 st_q <= ST_CMD;
            endcase
          end
          ST_WAIT: if (wait_exit_i)
            st_q <= ((op_q == OP_WC0) || (op_q == OP_WC1)) ? ST_CMD : ST_RD;
          ST_ADDR, ST_WR, ST_RD: cnt_q <= cnt_q + CW'(1);
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    fl_dq_o = 8'h00;
    case (st_q)
      ST_CMD:  fl_dq_o = byte_msb(cmd_i, cidx);
      ST_ADDR: begin
        if (op_q == OP_COL)      fl_dq_o = byte_lsb({16'h0, col_i}, {1'b0, cnt_q[0]});
        else if (op_q == OP_ROW) fl_dq_o = byte_lsb(row_i, cnt_q[1:0]);
        else                     fl_dq_o = slot_byte;
      end
      ST_WR:   fl_dq_o = bulk ? buf_rdata_i : slot_byte;
      default: fl_dq_o = 8'h00;
    endcase
  end

  assign fl_cle_o     = (st_q == ST_CMD);
  assign fl_ale_o     = (st_q == ST_ADDR);
  assign fl_we_o      = (st_q == ST_CMD) || (st_q == ST_ADDR) || (st_q == ST_WR);
  assign fl_re_o      = (st_q == ST_RD);
  assign buf_addr_o   = cnt_q[BUF_AW-1:0];
  assign buf_we_o     = (st_q == ST_RD) && bulk;
  assign buf_wdata_o  = fl_dq_i;
  assign slot_we_o    = (st_q == ST_RD) && !bulk;
  assign slot_idx_o   = slot_q;
  assign slot_wdata_o = fl_dq_i;
  assign wait_run_o   = (st_q == ST_WAIT);
  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = done_q;
  assign timeout_o    = to_q;
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int BUF_AW = 8,
  parameter int TMO_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_sel_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              fl_cle_o,
  output logic              fl_ale_o,
  output logic              fl_we_o,
  output logic              fl_re_o,
  output logic [7:0]        fl_dq_o,
  input  logic [7:0]        fl_dq_i,
  input  logic              fl_rdy_i,
  output logic [BUF_AW-1:0] buf_addr_o,
  output logic              buf_we_o,
  output logic [7:0]        buf_wdata_o,
  input  logic [7:0]        buf_rdata_i
);
  localparam int CW = BUF_AW + 1;

  logic [31:0]      prog, cmd, row;
  logic [CW-1:0]    bcnt;
  logic [15:0]      col;
  logic [TMO_W-1:0] tmo;
  logic             col2, slot_we, wait_run, wait_exit, wait_exp;
  logic [1:0]       rowcyc, slot_idx;
  logic [7:0]       slot_wdata;

  nand_seq_regs #(.BUF_AW(BUF_AW), .TMO_W(TMO_W)) u_regs (
    .clk_i, .rst_ni,
    .busy_i       (busy_o),
    .cfg_we_i, .cfg_sel_i, .cfg_wdata_i,
    .slot_we_i    (slot_we),
    .slot_idx_i   (slot_idx),
    .slot_wdata_i (slot_wdata),
    .prog_o       (prog),
    .cmd_o        (cmd),
    .slot_o       (data_o),
    .bcnt_o       (bcnt),
    .col_o        (col),
    .row_o        (row),
    .tmo_o        (tmo),
    .col2_o       (col2),
    .rowcyc_o     (rowcyc)
  );

  nand_seq_wait #(.TMO_W(TMO_W)) u_wait (
    .clk_i, .rst_ni,
    .run_i     (wait_run),
    .rdy_i     (fl_rdy_i),
    .limit_i   (tmo),
    .exit_o    (wait_exit),
    .expired_o (wait_exp)
  );

  nand_seq_fsm #(.BUF_AW(BUF_AW)) u_fsm (
    .clk_i, .rst_ni, .start_i,
    .prog_i       (prog),
    .cmd_i        (cmd),
    .slot_i       (data_o),
    .bcnt_i       (bcnt),
    .col_i        (col),
    .row_i        (row),
    .col2_i       (col2),
    .rowcyc_i     (rowcyc),
    .wait_exit_i  (wait_exit),
    .wait_exp_i   (wait_exp),
    .wait_run_o   (wait_run),
    .busy_o, .done_o, .timeout_o,
    .slot_we_o    (slot_we),
    .slot_idx_o   (slot_idx),
    .slot_wdata_o (slot_wdata),
    .fl_cle_o, .fl_ale_o, .fl_we_o, .fl_re_o, .fl_dq_o, .fl_dq_i,
    .buf_addr_o, .buf_we_o, .buf_wdata_o, .buf_rdata_i
  );
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic timeout_o,
  input logic fl_cle_o,
  input logic fl_ale_o,
  input logic fl_we_o,
  input logic fl_re_o,
  input logic buf_we_o
);
  p_one_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fl_we_o && fl_re_o));

  p_cle_ale_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fl_cle_o && fl_ale_o));

  p_buf_we_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> fl_re_o);

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(fl_we_o || fl_re_o));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_ends_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));

  p_start_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  p_timeout_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !(start_i && !busy_o)) |=> timeout_o);
endmodule

bind nand_seq nand_seq_chk u_chk (
  .clk_i, .rst_ni, .start_i, .busy_o, .done_o, .timeout_o,
  .fl_cle_o, .fl_ale_o, .fl_we_o, .fl_re_o, .buf_we_o
);

// File: tb/nand_seq_bench.sv
module nand_seq_bench;
  localparam int BUF_AW = 8;
  localparam int K_CMD = 0, K_ADR = 1, K_WR = 2, K_RD = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_sel = '0;
  logic [31:0]       cfg_wdata = '0;
  logic [31:0]       data_o;
  logic              busy_o, done_o, timeout_o;
  logic              fl_cle_o, fl_ale_o, fl_we_o, fl_re_o;
  logic [7:0]        fl_dq_o, fl_dq_i;
  logic              fl_rdy = 1'b1;
  logic [BUF_AW-1:0] buf_addr_o;
  logic              buf_we_o;
  logic [7:0]        buf_wdata_o, buf_rdata_i;

  int n_chk = 0, n_fail = 0, n_strobe = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] rd_shadow = 8'h00;
  logic [7:0] rd_cnt;
  logic [7:0] mem [0:(1<<BUF_AW)-1];

  always #10 clk = ~clk;

  nand_seq #(.BUF_AW(BUF_AW)) u_nand_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .data_o, .busy_o, .done_o, .timeout_o,
    .fl_cle_o, .fl_ale_o, .fl_we_o, .fl_re_o, .fl_dq_o, .fl_dq_i,
    .fl_rdy_i(fl_rdy),
    .buf_addr_o, .buf_we_o, .buf_wdata_o, .buf_rdata_i
  );

  // flash model: each read strobe returns A0 + running read count
  always @(posedge clk or negedge rst_n)
    if (!rst_n) rd_cnt <= 8'h00;
    else if (fl_re_o) rd_cnt <= rd_cnt + 8'h01;
  assign fl_dq_i = 8'hA0 + rd_cnt;

  // page buffer model
  always @(posedge clk) if (buf_we_o) mem[buf_addr_o] <= buf_wdata_o;
  assign buf_rdata_i = mem[buf_addr_o];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic push(input int k, input logic [7:0] b, input string tag);
    exp_q.push_back({k[1:0], b});
    tag_q.push_back(tag);
  endtask

  task automatic push_rd(input string tag, output logic [7:0] v);
    v = 8'hA0 + rd_shadow;
    rd_shadow = rd_shadow + 8'h01;
    push(K_RD, v, tag);
  endtask

  // monitor: compare every strobe against the scoreboard
  always @(negedge clk) begin
    if (rst_n && (fl_we_o || fl_re_o)) begin
      logic [9:0] act, e;
      string t;
      int k;
      n_strobe++;
      k = fl_re_o ? K_RD : fl_cle_o ? K_CMD : fl_ale_o ? K_ADR : K_WR;
      act = {k[1:0], fl_re_o ? fl_dq_i : fl_dq_o};
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected strobe", {22'h0, act}, 32'h0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(act == e, t, {22'h0, act}, {22'h0, e});
      end
    end
  end

  task automatic cfg(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int g = 0;
    while (!done_o && g < 5000) begin
      @(negedge clk);
      g++;
    end
    chk(done_o && !busy_o, tag, {30'h0, done_o, busy_o}, 32'h2);
    @(negedge clk);
    chk(!done_o, "R10 done one cycle", {31'h0, done_o}, 32'h0);
    chk(exp_q.size() == 0, "R2 all strobes seen", exp_q.size(), 32'h0);
  endtask

  task automatic run(input logic [31:0] prog, input string tag);
    cfg(3'd0, prog);
    pulse_start();
    wait_done(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v0, v1, v2, b0, b1;
    int s0;
    for (int i = 0; i < (1 << BUF_AW); i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and empty program
    chk(data_o == 0 && !busy_o && !done_o && !timeout_o, "R1 reset outputs",
        {data_o[28:0], busy_o, done_o, timeout_o}, 32'h0);
    s0 = n_strobe;
    pulse_start();
    wait_done("R1 empty program done");
    chk(n_strobe == s0, "R1 no strobe", n_strobe - s0, 32'h0);

    // R3 command byte order
    cfg(3'd1, 32'h1122_3344);
    push(K_CMD, 8'h11, "R3 cmd0"); push(K_CMD, 8'h22, "R3 cmd1");
    push(K_CMD, 8'h33, "R3 cmd2"); push(K_CMD, 8'h44, "R3 cmd3");
    run(32'h4567_0000, "R3 done");
    // R2 end opcode stops execution
    push(K_CMD, 8'h44, "R2 first nibble"); push(K_CMD, 8'h11, "R2 second nibble");
    run(32'h7400_4000, "R2 stop at end opcode");

    // R4 R5 address cycles
    cfg(3'd4, 32'h0000_BEEF);
    cfg(3'd5, 32'h00A1_B2C3);
    cfg(3'd7, 32'h5);
    push(K_CMD, 8'h11, "R3 cmd before addr");
    push(K_ADR, 8'hEF, "R4 col lo"); push(K_ADR, 8'hBE, "R4 col hi");
    push(K_ADR, 8'hC3, "R5 row b0"); push(K_ADR, 8'hB2, "R5 row b1");
    push(K_ADR, 8'hA1, "R5 row b2");
    run(32'h4120_0000, "R4 done");
    cfg(3'd7, 32'h0);
    push(K_ADR, 8'hEF, "R4 col one cycle"); push(K_ADR, 8'hC3, "R5 row one cycle");
    run(32'h1200_0000, "R5 done");

    // R6 slot pointer with wrap
    cfg(3'd2, 32'hD0D1_D2D3);
    push(K_ADR, 8'hD0, "R6 slot0 addr"); push(K_WR, 8'hD1, "R6 slot1 write");
    push(K_ADR, 8'hD2, "R6 slot2 addr"); push(K_WR, 8'hD3, "R6 slot3 write");
    push(K_ADR, 8'hD0, "R6 wrap to slot0");
    run(32'h3939_3000, "R6 done");
    push_rd("R6 read slot0", v0); push_rd("R6 read slot1", v1); push_rd("R6 read slot2", v2);
    run(32'hBBB0_0000, "R6 reads done");
    chk(data_o == {v0, v1, v2, 8'hD3}, "R6 slots filled", data_o, {v0, v1, v2, 8'hD3});

    // R7 bulk transfers
    for (int i = 0; i < 5; i++) mem[i] = 8'h50 + 8'(i);
    cfg(3'd3, 32'd5);
    for (int i = 0; i < 5; i++) push(K_WR, 8'h50 + 8'(i), "R7 bulk write");
    run(32'h8000_0000, "R7 write done");
    push_rd("R7 bulk read", b0); push_rd("R7 bulk read", b1);
    push_rd("R7 bulk read", v0); push_rd("R7 bulk read", v1); push_rd("R7 bulk read", v2);
    run(32'hA000_0000, "R7 read done");
    chk({mem[0], mem[1], mem[2], mem[3], mem[4]} == {b0, b1, v0, v1, v2}, "R7 buffer contents",
        {mem[0], mem[1], mem[2], mem[3]}, {b0, b1, v0, v1});
    cfg(3'd3, 32'd0);
    push(K_CMD, 8'h11, "R7 zero count skips data");
    run(32'h8400_0000, "R7 zero count done");

    // R8 wait for ready
    push(K_CMD, 8'h11, "R8 ready high cmd0");
    run(32'hC000_0000, "R8 immediate done");
    fl_rdy = 1'b0;
    cfg(3'd6, 32'd1000);
    cfg(3'd0, 32'hD000_0000);
    s0 = n_strobe;
    pulse_start();
    repeat (20) @(negedge clk);
    chk(n_strobe == s0 && busy_o, "R8 held while not ready", n_strobe - s0, 32'h0);
    push(K_CMD, 8'h22, "R8 cmd1 after ready");
    fl_rdy = 1'b1;
    wait_done("R8 wait done");
    chk(!timeout_o, "R8 no timeout", {31'h0, timeout_o}, 32'h0);

    // R9 timeout
    fl_rdy = 1'b0;
    cfg(3'd6, 32'd10);
    cfg(3'd2, 32'h0);
    push_rd("R9 read after timeout", v0);
    run(32'hF000_0000, "R9 done");
    chk(timeout_o, "R9 timeout set", {31'h0, timeout_o}, 32'h1);
    chk(data_o == {v0, 24'h0}, "R9 read stored", data_o, {v0, 24'h0});
    cfg(3'd3, 32'd2);
    push_rd("R9 bulk after timeout", b0); push_rd("R9 bulk after timeout", b1);
    run(32'hE000_0000, "R9 bulk done");
    chk({mem[0], mem[1]} == {b0, b1}, "R9 bulk stored", {16'h0, mem[0], mem[1]}, {16'h0, b0, b1});
    chk(timeout_o, "R9 sticky", {31'h0, timeout_o}, 32'h1);
    fl_rdy = 1'b1;
    push(K_CMD, 8'h11, "R9 next run");
    run(32'h4000_0000, "R9 next done");
    chk(!timeout_o, "R9 cleared by start", {31'h0, timeout_o}, 32'h0);

    // R2 eight opcodes then completion
    for (int i = 0; i < 8; i++) push(K_CMD, 8'h11, "R2 eighth opcode run");
    run(32'h4444_4444, "R2 eight done");

    // R10 writes and start ignored while busy
    cfg(3'd2, 32'hCAFE_0001);
    fl_rdy = 1'b0;
    cfg(3'd6, 32'd1000);
    cfg(3'd0, 32'hC400_0000);
    pulse_start();
    chk(busy_o, "R10 busy after start", {31'h0, busy_o}, 32'h1);
    cfg(3'd1, 32'hFFFF_FFFF);
    cfg(3'd2, 32'h1234_5678);
    cfg(3'd0, 32'h5555_5555);
    pulse_start();
    push(K_CMD, 8'h11, "R10 old cmd kept"); push(K_CMD, 8'h11, "R10 old cmd kept");
    fl_rdy = 1'b1;
    wait_done("R10 done");
    chk(data_o == 32'hCAFE_0001, "R10 slot write ignored", data_o, 32'hCAFE_0001);
    s0 = n_strobe;
    repeat (10) @(negedge clk);
    chk(!busy_o && n_strobe == s0, "R10 restart ignored", n_strobe - s0, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule